// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects a parameterised number of interrupt sources and decides whether the processor core should be asked to take an interrupt, and at which address. Each source has three control bits: a sticky pending flag, a per-source enable and a level bit. Software reaches all of them through a register write port. A flag read port returns the pending vector, so that software can identify which source fired.

A run-time mode bit selects between two policies. In two-level mode, each level has its own global enable. High-level sources are taken at address 0x000008 and low-level sources at 0x000018. Entering a level clears only that level's enable, so a high request can interrupt a low service. In single-level mode the level bits are ignored. One global enable gates every source, a group enable additionally gates a fixed peripheral subset, and every request is taken at 0x000008.

The core sees a registered request and its address. It answers with an acknowledge pulse and later a return pulse. A small level tracker records whether a low service, a high service, or a high service nested inside a low one is in progress. On return it re-arms only the enable of the level being left.

Top module: `prio_intc`

## Requirements
- R1: A one-cycle pulse on `src_evt[i]` sets pending flag i at the next clock edge, whatever the enables, mode or service state are; `flag_rd` shows the flags.
- R2: Flags change only through events or a write with `wr_sel`=0, which loads `wr_data` into the flags; an event in the same cycle as such a write still leaves its flag set.
- R3: After reset all flags, enables, level bits and control bits are 0 (single-level mode, both global enables off), `irq_req` is 0 and no service is in progress.
- R4: Write selects are `wr_sel`=1 for enables, 2 for level bits (1 = high) and 3 for control, where `wr_data[0]` is the mode (1 = two-level), `wr_data[1]` the upper enable and `wr_data[2]` the lower enable. In two-level mode a pending, enabled high source requests while the upper enable is set, at vector 0x000008. A pending, enabled low source requests while the lower enable is set, at vector 0x000018. High wins when both qualify.
- R5: In single-level mode the level bits are ignored and the vector is always 0x000008. The upper enable acts as the global enable. Sources in the peripheral mask (default: sources 4 to 7) also need the lower enable, which acts as the group enable.
- R6: `irq_req` and `irq_vec` are registered. A qualifying condition present after clock edge t shows on `irq_req` after edge t+1. The request is withheld for one cycle after any register write or accepted acknowledge. It is never high while the enable that applies to its vector is clear.
- R7: An `irq_ack` while `irq_req` is high is accepted. Accepting vector 0x000008 clears the upper enable. Accepting 0x000018 clears the lower enable. An `irq_ack` while `irq_req` is low has no effect.
- R8: A high request is raised during a low service, and accepting it nests the services. No low request is raised while a high service is in progress.
- R9: An `irq_ret` pulse outside an accepted-acknowledge cycle ends the innermost service. Leaving a high service sets the upper enable, and a nested high service returns to the low service. Leaving a low service sets the lower enable. With no service in progress, `irq_ret` is ignored.
- R10: A flag still set when its enable is re-armed by a return raises a new request without any new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | N_SRC | Source event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 flags, 1 enables, 2 levels, 3 control |
| wr_data | input | N_SRC | Write data |
| flag_rd | output | N_SRC | Pending flag vector |
| irq_req | output | 1 | Registered vector request to the core |
| irq_vec | output | VEC_W | Vector address, valid while irq_req is high |
| irq_ack | input | 1 | Core accepts the current request |
| irq_ret | input | 1 | Core returns from the current service |

## Verification
The hardest state to reach is a high service nested inside a low one, followed by the return back into the low service while flags of both levels are still pending. From the ports this takes a two-level configuration, a low event and its acceptance, then a high event and its acceptance, all before any return. The directed part of the bench walks this chain and then checks the re-arming order. A seeded random phase follows, with sparse events, acknowledges, returns and flag-clearing writes, so that mode changes in mid-service and stale requests are also met. Every cycle is compared against a reference model in bench functions.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 24,
  parameter logic [VEC_W-1:0] HI_VEC = 24'h000008,
  parameter logic [VEC_W-1:0] LO_VEC = 24'h000018,
  parameter logic [N_SRC-1:0] PERIPH_MASK = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_evt,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [N_SRC-1:0] wr_data,
  output logic [N_SRC-1:0] flag_rd,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack,
  input  logic             irq_ret
);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_LOW = 2'd1, ST_HIGH = 2'd2, ST_NEST = 2'd3;

  logic [N_SRC-1:0] flags, en, lvl_bit;
  logic             pmode, up_en, lo_en;
  logic [1:0]       lvl;
  logic             req_q;
  logic [VEC_W-1:0] vec_q;

  wire [N_SRC-1:0] live    = flags & en;
  wire             hi_pend = up_en && |(live & lvl_bit);
  wire             lo_pend = lo_en && |(live & ~lvl_bit) && !lvl[1];
  wire             cm_pend = up_en && |(live & (~PERIPH_MASK | {N_SRC{lo_en}}));
  wire             want    = pmode ? (hi_pend || lo_pend) : cm_pend;
  wire [VEC_W-1:0] pick    = (pmode && !hi_pend) ? LO_VEC : HI_VEC;
  wire             take    = irq_ack && req_q;
  wire             take_lo = take && (vec_q == LO_VEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      en      <= '0;
      lvl_bit <= '0;
      pmode   <= 1'b0;
      up_en   <= 1'b0;
      lo_en   <= 1'b0;
      lvl     <= ST_IDLE;
      req_q   <= 1'b0;
      vec_q   <= HI_VEC;
    end else begin
      req_q <= want && !take && !wr_en;
      vec_q <= pick;
      flags <= ((wr_en && wr_sel == 2'd0) ? wr_data : flags) | src_evt;
      if (wr_en && wr_sel == 2'd1) en <= wr_data;
      if (wr_en && wr_sel == 2'd2) lvl_bit <= wr_data;
      if (wr_en && wr_sel == 2'd3) {lo_en, up_en, pmode} <= wr_data[2:0];
      if (take) begin
        if (take_lo) begin
          lo_en <= 1'b0;
          lvl   <= ST_LOW;
        end else begin
          up_en <= 1'b0;
          lvl   <= (lvl == ST_LOW) ? ST_NEST : ST_HIGH;
        end
      end else if (irq_ret) begin
        case (lvl)
          ST_HIGH: begin up_en <= 1'b1; lvl <= ST_IDLE; end
          ST_NEST: begin up_en <= 1'b1; lvl <= ST_LOW;  end
          ST_LOW:  begin lo_en <= 1'b1; lvl <= ST_IDLE; end
          default: ;
        endcase
      end
    end
  end

  assign flag_rd = flags;
  assign irq_req = req_q;
  assign irq_vec = vec_q;
endmodule

module prio_intc_chk #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 24,
  parameter logic [VEC_W-1:0] HI_VEC = 24'h000008,
  parameter logic [VEC_W-1:0] LO_VEC = 24'h000018
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_evt,
  input logic [N_SRC-1:0] flag_rd,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_ack,
  input logic             irq_ret,
  input logic             pmode,
  input logic             up_en,
  input logic             lo_en,
  input logic [1:0]       lvl
);
  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((flag_rd & $past(src_evt)) == $past(src_evt)));
  // R6
  hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec == HI_VEC) |-> up_en);
  // R6
  lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && pmode && irq_vec == LO_VEC) |-> lo_en);
  // R5
  single_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !pmode) |-> (irq_vec == HI_VEC && up_en));
  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !irq_req);
  // R7
  ack_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == HI_VEC) |=> (!up_en && lvl[1]));
  // R7
  ack_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == LO_VEC) |=> (!lo_en && lvl == 2'd1));
  // R8
  no_lo_over_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec == LO_VEC) |-> !lvl[1]);
  // R9
  nest_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 2'd3 && irq_ret && !(irq_ack && irq_req)) |=> (lvl == 2'd1 && up_en));
endmodule

bind prio_intc prio_intc_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .flag_rd(flag_rd), .irq_req(irq_req),
  .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret), .pmode(pmode),
  .up_en(up_en), .lo_en(lo_en), .lvl(lvl)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int N = 8;
  localparam logic [23:0] HV = 24'h000008, LV = 24'h000018;
  localparam logic [N-1:0] PM = 8'hF0;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_evt = '0, wr_data = '0;
  logic wr_en = 0, irq_ack = 0, irq_ret = 0;
  logic [1:0] wr_sel = '0;
  logic [N-1:0] flag_rd;
  logic irq_req;
  logic [23:0] irq_vec;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  prio_intc uut (.clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .flag_rd(flag_rd), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_ret(irq_ret));

  // reference model
  logic [N-1:0] mf = '0, me = '0, mp = '0;
  logic mmode = 0, mup = 0, mlo = 0, mreq = 0;
  logic [23:0] mvec = HV;
  int mst = 0; // 0 idle, 1 low, 2 high, 3 high nested in low

  function automatic logic m_want();
    logic h, l;
    h = mup && |(mf & me & mp);
    l = mlo && |(mf & me & ~mp) && (mst < 2);
    if (mmode) return h || l;
    return mup && |(mf & me & (~PM | {N{mlo}}));
  endfunction

  function automatic logic [23:0] m_pick();
    if (mmode && !(mup && |(mf & me & mp))) return LV;
    return HV;
  endfunction

  task automatic m_update(input logic [N-1:0] ev, input logic we, input logic [1:0] sel,
                          input logic [N-1:0] d, input logic ack, input logic ret);
    logic w, tk;
    logic [23:0] v;
    w = m_want();
    v = m_pick();
    tk = ack && mreq;
    if (we && sel == 2'd0) mf = d;
    mf = mf | ev;
    if (we && sel == 2'd1) me = d;
    if (we && sel == 2'd2) mp = d;
    if (we && sel == 2'd3) begin mmode = d[0]; mup = d[1]; mlo = d[2]; end
    if (tk) begin
      if (mvec == LV) begin mlo = 0; mst = 1; end
      else begin mup = 0; mst = (mst == 1) ? 3 : 2; end
    end else if (ret) begin
      case (mst)
        2: begin mup = 1; mst = 0; end
        3: begin mup = 1; mst = 1; end
        1: begin mlo = 1; mst = 0; end
        default: ;
      endcase
    end
    mreq = w && !tk && !we;
    mvec = v;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] ev, input logic we, input logic [1:0] sel,
                      input logic [N-1:0] d, input logic ack, input logic ret);
    @(negedge clk);
    src_evt = ev; wr_en = we; wr_sel = sel; wr_data = d; irq_ack = ack; irq_ret = ret;
    @(posedge clk);
    m_update(ev, we, sel, d, ack, ret);
    #1;
    chk("R6 model req", {31'd0, irq_req}, {31'd0, mreq});
    if (mreq) chk("R4 model vec", {8'd0, irq_vec}, {8'd0, mvec});
    chk("R1 model flags", {24'd0, flag_rd}, {24'd0, mf});
  endtask

  task automatic idle(); step('0, 0, 2'd0, '0, 0, 0); endtask
  task automatic wr(input logic [1:0] s, input logic [N-1:0] d); step('0, 1, s, d, 0, 0); endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R3 reset req", {31'd0, irq_req}, 0);
    chk("R3 reset flags", {24'd0, flag_rd}, 0);
    idle();
    chk("R3 idle req", {31'd0, irq_req}, 0);

    step(8'h01, 0, 0, 0, 0, 0);
    chk("R1 flag set with enables off", {24'd0, flag_rd}, 32'h01);
    idle();
    chk("R5 no request with global off", {31'd0, irq_req}, 0);
    step(8'h02, 1, 2'd0, 8'h00, 0, 0);
    chk("R2 write clears, event wins", {24'd0, flag_rd}, 32'h02);

    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h02);
    chk("R6 withheld on write", {31'd0, irq_req}, 0);
    idle();
    chk("R6 request one cycle later", {31'd0, irq_req}, 1);
    chk("R5 single-level vector", {8'd0, irq_vec}, {8'd0, HV});
    step('0, 0, 0, 0, 1, 0);
    chk("R7 request drops on ack", {31'd0, irq_req}, 0);
    idle(); idle();
    chk("R7 global cleared blocks flag", {31'd0, irq_req}, 0);
    step('0, 0, 0, 0, 0, 1);
    idle();
    chk("R10 set flag re-requests after return", {31'd0, irq_req}, 1);
    step('0, 0, 0, 0, 1, 0);
    wr(2'd0, 8'h00);
    step('0, 0, 0, 0, 0, 1);
    step(8'h20, 0, 0, 0, 0, 0);
    idle(); idle();
    chk("R5 peripheral source gated by group enable", {31'd0, irq_req}, 0);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h06);
    idle();
    chk("R5 group enable opens peripheral source", {31'd0, irq_req}, 1);
    chk("R5 level bits ignored", {8'd0, irq_vec}, {8'd0, HV});
    step('0, 0, 0, 0, 1, 0);
    wr(2'd0, 8'h00);
    step('0, 0, 0, 0, 0, 1);

    wr(2'd2, 8'h0F);
    wr(2'd3, 8'h07);
    step(8'h20, 0, 0, 0, 0, 0);
    idle();
    chk("R4 low request", {31'd0, irq_req}, 1);
    chk("R4 low vector", {8'd0, irq_vec}, {8'd0, LV});
    step('0, 0, 0, 0, 1, 0);
    step(8'h02, 0, 0, 0, 0, 0);
    idle();
    chk("R8 high preempts low", {31'd0, irq_req}, 1);
    chk("R8 preempt vector", {8'd0, irq_vec}, {8'd0, HV});
    step('0, 0, 0, 0, 1, 0);
    step(8'h40, 0, 0, 0, 0, 0);
    idle(); idle();
    chk("R8 low blocked in high service", {31'd0, irq_req}, 0);
    step('0, 0, 0, 0, 0, 1);
    idle();
    chk("R9 nested return re-arms high only", {31'd0, irq_req}, 1);
    chk("R10 high flag re-requests", {8'd0, irq_vec}, {8'd0, HV});
    wr(2'd0, 8'h60);
    idle();
    chk("R9 low still masked in low service", {31'd0, irq_req}, 0);
    step('0, 0, 0, 0, 0, 1);
    idle();
    chk("R9 low return re-arms low", {31'd0, irq_req}, 1);
    chk("R9 low vector after return", {8'd0, irq_vec}, {8'd0, LV});
    step(8'h04, 0, 0, 0, 0, 0);
    idle();
    chk("R4 high wins over low", {8'd0, irq_vec}, {8'd0, HV});
    wr(2'd0, 8'h00);
    idle();
    step('0, 0, 0, 0, 1, 0);
    chk("R7 ack without request ignored", {31'd0, irq_req}, 0);
    step(8'h08, 0, 0, 0, 0, 0);
    idle();
    chk("R7 ignored ack left enable set", {31'd0, irq_req}, 1);

    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] ev, d;
      logic we;
      logic [1:0] s;
      ev = ($urandom % 6 == 0) ? (8'h01 << ($urandom % N)) : '0;
      we = ($urandom % 9 == 0);
      s = 2'($urandom % 4);
      d = 8'($urandom);
      if (s == 2'd0) d = mf & d;
      if (s == 2'd3 && ($urandom % 3 != 0)) d[2:1] = 2'b11;
      step(ev, we, s, d, ($urandom % 3 == 0), ($urandom % 10 == 0));
    end
    summary();
  end
endmodule